// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block is the transmit serialiser of a 16550-class UART. A host writes a byte into a single holding register with a one-cycle load strobe. When the shifter is free, the byte moves into a shift register on the next 16x baud tick. The shifter then sends a frame on the serial line: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and 1, 1.5 or 2 high stop bits. Every bit lasts 16 baud ticks, and a half stop bit lasts 8.

The frame format comes from a line-control byte that can change at run time. The block samples it once, when a frame starts, so a setting written during a frame applies to the next one. A break-control bit pulls the serial output low for as long as it is set. The shifter keeps counting underneath, so the frame timing is not changed. Two flags report whether the holding register is empty and whether the whole transmitter is empty.

Top module: `uart_frame_tx`

## Requirements
- R1: line_ctrl[1:0] selects the word length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent from load_data[0] upward, and bits above the word length are not sent.
- R2: With line_ctrl[2]=0 the frame has 1 stop bit (16 ticks). With line_ctrl[2]=1 it has 1.5 stop bits (24 ticks) for 5-bit words and 2 stop bits (32 ticks) for 6, 7 or 8-bit words.
- R3: line_ctrl[3]=1 adds a parity bit after the data. If line_ctrl[5]=0, then line_ctrl[4]=1 gives even parity and line_ctrl[4]=0 gives odd parity, counted over the sent data bits only.
- R4: With line_ctrl[3]=1 and line_ctrl[5]=1, the parity bit is the constant inverse of line_ctrl[4]: 0 when bit 4 is set and 1 when it is clear.
- R5: While line_ctrl[6]=1, txd is 0. The frame keeps its timing underneath, so releasing the break mid-frame shows the current bit of the frame, and the frame ends at its normal time.
- R6: hold_empty is 1 exactly when the holding register is empty, and it drops in the cycle after a load. tx_empty is 1 only when the holding register and the shifter are both empty. Both flags are 1 after reset.
- R7: The idle line is high. A frame is a start bit of 0 followed by the data, parity and stop bits, and each start, data and parity bit lasts 16 baud ticks.
- R8: Line-control settings are sampled when a frame starts. A change made during a frame applies only to the next frame.
- R9: A loaded byte moves to the shifter on the next baud tick when the shifter is idle, or on the tick that ends the stop bits of the current frame. hold_empty rises at that transfer. Back-to-back frames have no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| line_ctrl | input | 7 | Line control: [1:0] word length, [2] stop, [3] parity enable, [4] even, [5] stick, [6] break |
| load | input | 1 | Strobe that writes load_data into the holding register |
| load_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shifter are both empty |

## Verification
The hardest cases to reach are stop-bit lengths that are exact to the tick and a change of settings between frames. Both appear only when a new frame starts straight after the last stop tick. The stimulus therefore reloads the holding register as soon as hold_empty rises, with a new line-control value each time. The monitor then measures the high run before the next start bit in ticks. A break is asserted during a frame and released mid-frame, and the bench then checks the data bit that follows and the tick on which tx_empty rises.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [6:0] line_ctrl,
  input  logic       load,
  input  logic [7:0] load_data,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);
  localparam int CW = $clog2(2 * OSR + 1);
  localparam logic [CW-1:0] BIT_T  = CW'(OSR);
  localparam logic [CW-1:0] HALF_T = CW'(OSR + OSR / 2);
  localparam logic [CW-1:0] TWO_T  = CW'(2 * OSR);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t state;

  logic [7:0]    hold_q, shift_q;
  logic          hold_full;
  logic [2:0]    bit_idx;
  logic [CW-1:0] tcnt, stop_q;
  logic [1:0]    wlen_q;
  logic          par_en_q, par_q;

  logic [7:0]    mask;
  logic          par_calc;
  logic [CW-1:0] stop_calc, limit;
  logic          last, go, line_bit;

  assign mask      = 8'hFF >> (2'd3 - line_ctrl[1:0]);
  assign par_calc  = line_ctrl[5] ? ~line_ctrl[4]
                   : (line_ctrl[4] ? ^(hold_q & mask) : ~^(hold_q & mask));
  assign stop_calc = !line_ctrl[2] ? BIT_T : (line_ctrl[1:0] == 2'd0 ? HALF_T : TWO_T);
  assign limit     = (state == S_STOP) ? stop_q : BIT_T;
  assign last      = baud_tick && (tcnt == limit - CW'(1));
  assign go        = baud_tick && hold_full && (state == S_IDLE || (state == S_STOP && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (go) hold_full <= 1'b0;
      if (load) begin
        hold_q    <= load_data;
        hold_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      shift_q  <= '0;
      bit_idx  <= '0;
      tcnt     <= '0;
      stop_q   <= BIT_T;
      wlen_q   <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
    end else if (go) begin
      state    <= S_START;
      shift_q  <= hold_q;
      tcnt     <= '0;
      stop_q   <= stop_calc;
      wlen_q   <= line_ctrl[1:0];
      par_en_q <= line_ctrl[3];
      par_q    <= par_calc;
    end else if (state != S_IDLE && baud_tick) begin
      tcnt <= last ? '0 : tcnt + CW'(1);
      if (last) begin
        unique case (state)
          S_START: begin
            state   <= S_DATA;
            bit_idx <= '0;
          end
          S_DATA: begin
            shift_q <= shift_q >> 1;
            if (bit_idx == {1'b1, wlen_q}) state <= par_en_q ? S_PAR : S_STOP;
            else bit_idx <= bit_idx + 3'd1;
          end
          S_PAR:   state <= S_STOP;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      S_START: line_bit = 1'b0;
      S_DATA:  line_bit = shift_q[0];
      S_PAR:   line_bit = par_q;
      default: line_bit = 1'b1;
    endcase
  end

  assign txd        = line_bit & ~line_ctrl[6];
  assign hold_empty = ~hold_full;
  assign tx_empty   = ~hold_full && state == S_IDLE;

  a_r6_temt_needs_thre: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);
  a_r6_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !hold_empty);
  a_r9_transfer_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(baud_tick));
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_START |-> $stable({wlen_q, stop_q, par_en_q, par_q}));
  a_r2_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < stop_q);
  a_r5_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctrl[6] |-> !txd);
endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [6:0] line_ctrl = '0;
  logic       load = 1'b0;
  logic [7:0] load_data = '0;
  logic       txd, hold_empty, tx_empty;

  int n_checks = 0;
  int n_fail = 0;
  int tick_count = 0;
  bit mon_en = 1'b1;

  typedef struct {
    logic [7:0] data;
    int         nb;
    bit         has_par;
    bit         par;
    int         stop_len;
  } exp_t;
  exp_t exp_q[$];

  uart_frame_tx #(.OSR(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
    .load(load), .load_data(load_data), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  always @(posedge clk) if (baud_tick) tick_count++;

  task automatic wait_tick();
    int t = tick_count;
    do @(negedge clk); while (tick_count == t);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t make_exp(logic [6:0] lc, logic [7:0] d);
    exp_t e;
    logic [7:0] m;
    e.nb = 5 + int'(lc[1:0]);
    m = 8'hFF >> (3 - int'(lc[1:0]));
    e.data = d & m;
    e.has_par = lc[3];
    if (lc[5]) e.par = ~lc[4];
    else if (lc[4]) e.par = ^e.data;
    else e.par = ~^e.data;
    if (!lc[2]) e.stop_len = 16;
    else if (lc[1:0] == 2'b00) e.stop_len = 24;
    else e.stop_len = 32;
    return e;
  endfunction

  task automatic send(logic [6:0] lc, logic [7:0] d);
    while (!hold_empty) @(negedge clk);
    line_ctrl = lc;
    load_data = d;
    load = 1'b1;
    exp_q.push_back(make_exp(lc, d));
    @(negedge clk);
    load = 1'b0;
    check(hold_empty == 1'b0, "R6", "hold_empty after load", int'(hold_empty), 0);
  endtask

  initial begin : monitor
    bit have_start;
    exp_t e;
    logic [7:0] got;
    bit par_got, ok_start;
    int cnt;
    bit stop_ok;
    have_start = 1'b0;
    forever begin
      if (!have_start) begin
        do wait_tick(); while (!(mon_en && txd === 1'b0));
      end
      have_start = 1'b0;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected frame", 0, 1);
        e = make_exp(7'h03, 8'h00);
      end else e = exp_q.pop_front();
      repeat (8) wait_tick();
      ok_start = (txd === 1'b0);
      got = '0;
      for (int j = 0; j < e.nb; j++) begin
        repeat (16) wait_tick();
        got[j] = txd;
      end
      par_got = 1'b0;
      if (e.has_par) begin
        repeat (16) wait_tick();
        par_got = txd;
      end
      repeat (8) wait_tick();
      cnt = 0;
      while (txd === 1'b1 && cnt < e.stop_len + 48) begin
        cnt++;
        wait_tick();
      end
      if (txd === 1'b0) begin
        have_start = 1'b1;
        stop_ok = (cnt == e.stop_len);
      end else stop_ok = (cnt >= e.stop_len);
      check(ok_start, "R7", "start bit", int'(!ok_start), 0);
      check(got == e.data, "R1", "data bits", int'(got), int'(e.data));
      if (e.has_par) check(par_got == e.par, e.par == 1'b1 ? "R3/R4" : "R3/R4",
                           "parity bit", int'(par_got), int'(e.par));
      check(stop_ok, "R2", "stop ticks", cnt, e.stop_len);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : driver
    int n;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R7", "idle line after reset", int'(txd), 1);
    check(hold_empty == 1'b1, "R6", "hold_empty after reset", int'(hold_empty), 1);
    check(tx_empty == 1'b1, "R6", "tx_empty after reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R7", "idle line", int'(txd), 1);

    send(7'h03, 8'hA5);
    while (!hold_empty) @(negedge clk);
    check(tx_empty == 1'b0, "R6", "tx_empty while shifting", int'(tx_empty), 0);
    // R8 and R9: each frame is reloaded during the previous one with new settings
    send(7'h1B, 8'h3C);
    send(7'h0B, 8'h3C);
    send(7'h00, 8'h15);
    send(7'h04, 8'h0D);
    send(7'h05, 8'h2A);
    send(7'h06, 8'h7F);
    send(7'h07, 8'hC3);
    send(7'h2B, 8'h01);
    send(7'h3B, 8'hFE);
    send(7'h1A, 8'h55);
    send(7'h0C, 8'h1F);
    while (!tx_empty) @(negedge clk);
    check(hold_empty == 1'b1, "R6", "hold_empty when all sent", int'(hold_empty), 1);
    check(exp_q.size() == 0, "R9", "frames outstanding", exp_q.size(), 0);
    repeat (100) wait_tick();

    mon_en = 1'b0;
    line_ctrl = 7'h43;
    @(negedge clk);
    check(txd == 1'b0, "R5", "break on idle line", int'(txd), 0);
    load_data = 8'hA5;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    while (!hold_empty) @(negedge clk);
    n = 0;
    while (n < 24) begin wait_tick(); n++; end
    check(txd == 1'b0, "R5", "break over data bit 0", int'(txd), 0);
    while (n < 50) begin wait_tick(); n++; end
    line_ctrl = 7'h03;
    while (n < 56) begin wait_tick(); n++; end
    check(txd == 1'b1, "R5", "data bit 2 after break", int'(txd), 1);
    while (n < 72) begin wait_tick(); n++; end
    check(txd == 1'b0, "R5", "data bit 3 after break", int'(txd), 0);
    while (n < 136) begin wait_tick(); n++; end
    check(txd == 1'b1, "R5", "data bit 7 after break", int'(txd), 1);
    while (n < 159) begin wait_tick(); n++; end
    check(tx_empty == 1'b0, "R5", "tx_empty one tick early", int'(tx_empty), 0);
    wait_tick();
    check(tx_empty == 1'b1, "R5", "tx_empty at frame end", int'(tx_empty), 1);
    check(txd == 1'b1, "R7", "idle after break frame", int'(txd), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule